// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives one peripheral bus clock from its parent clock with a programmable integer ratio from 1 to 128. Software controls it through a single 16-bit control word. A write sets the divisor field and the run enable together. A read returns those fields and a read-only ready flag.

Every write drops the ready flag. The new ratio is not taken at once. It waits for the end of the output period that is running, so the output never shows a cut-short phase. Ready comes back high one cycle after the new ratio has been taken. Software must see ready high before it writes again.

The enable bit stops or restarts the output. Like the ratio, it acts only at a period boundary. Clearing it keeps the stored divisor, so setting it again restarts the output at the same rate.

Top module: `pbclk_div`

## Requirements
- R1: Bits 6:0 of the control word hold the divisor code. The divide ratio is the code plus one (1 to 128). A read returns the code last written, and the code does not change without a write.
- R2: For a ratio of 2 or more, each output period starts with a high phase of floor(ratio/2) parent cycles, followed by a low phase for the rest of the period. For a ratio of 1, the output is the parent clock itself: high while the parent is high and low while it is low.
- R3: Bit 11 is a read-only ready flag. It reads 0 from the cycle after any write. Writing this bit has no effect.
- R4: Ready reads 1 again on the cycle after the new ratio is taken. From then on, the divisor field reads back the newly written code.
- R5: A new ratio is taken only at the end of the running output period. While a change is in progress, every complete high or low run has either the old ratio's length or the new ratio's length.
- R6: Clearing bit 15 (enable) stops the output at the next period boundary, leaving it held low. The divisor code is kept.
- R7: Setting bit 15 again restarts the output at a period boundary, with full-length phases at the stored ratio.
- R8: After reset, the control word reads 0x0800 (ready high, enable off, code 0) and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word to write (divisor 6:0, enable 15) |
| rd_data_o | output | 16 | Control word read value (divisor 6:0, ready 11, enable 15) |
| pb_clk_o | output | 1 | Divided, gated peripheral bus clock |

## Verification
Ready falls on the first parent edge after the write edge, so the bench checks it at the falling edge that follows that write cycle. Ready rises one edge after the new ratio is taken, and that can be up to one full old period later. The bench therefore polls ready at falling edges within a bounded wait before it measures anything.

For ratios of 2 or more, the output comes from a register updated on the rising edge. The bench takes one sample per parent cycle at falling edges, counts the high and low runs, and compares them with tabled lengths.

The ratio-1 path follows the parent clock itself. The bench checks it one time unit after the rising edge, where it must be high, and just after the falling edge, where it must be low.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;

   // Number of parent cycles the output stays high for a divisor code.
   function automatic int unsigned high_len(input int unsigned code);
      return (code + 1) / 2;
   endfunction

   // Width of a counter that can hold a value up to and including lim.
   function automatic int unsigned cnt_width(input int unsigned lim);
      int unsigned w;
      w = 1;
      while ((1 << w) <= lim) w++;
      return w;
   endfunction

endpackage

// File: rtl/pbdiv_regs.sv
module pbdiv_regs #(
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned REG_W   = 16,
   parameter int unsigned RDY_BIT = 11,
   parameter int unsigned EN_BIT  = 15,
   parameter int unsigned RST_DIV = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             load_i,
   output logic [DIV_W-1:0] div_o,
   output logic             en_o,
   output logic             pend_o,
   output logic [REG_W-1:0] rd_data_o
);

   logic [DIV_W-1:0] div_q;
   logic             en_q;
   logic             pend_q;
   logic             rdy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= DIV_W'(RST_DIV);
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         rdy_q  <= 1'b1;
      end else begin
         if (wr_en_i) begin
            div_q  <= wr_data_i[DIV_W-1:0];
            en_q   <= wr_data_i[EN_BIT];
            pend_q <= 1'b1;
            rdy_q  <= 1'b0;
         end else begin
            if (load_i) pend_q <= 1'b0;
            rdy_q <= !pend_q;
         end
      end
   end

   always_comb begin
      rd_data_o                = '0;
      rd_data_o[DIV_W-1:0]     = div_q;
      rd_data_o[RDY_BIT]       = rdy_q;
      rd_data_o[EN_BIT]        = en_q;
   end

   assign div_o  = div_q;
   assign en_o   = en_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/pbdiv_core.sv
module pbdiv_core #(
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned RST_DIV = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             en_i,
   input  logic             pend_i,
   output logic             load_o,
   output logic             phase_o,
   output logic             run_o,
   output logic [DIV_W-1:0] act_o,
   output logic [DIV_W-1:0] cnt_o
);

   localparam int unsigned CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q, cnt_n;
   logic [DIV_W-1:0] act_q, act_n;
   logic             run_q, run_n;
   logic             phase_q, phase_n;
   logic [CW-1:0]    half_n;
   logic             wrap;

   always_comb begin
      wrap    = (cnt_q == act_q);
      load_o  = wrap && pend_i;
      act_n   = load_o ? div_i : act_q;
      cnt_n   = wrap ? '0 : cnt_q + 1'b1;
      run_n   = wrap ? en_i : run_q;
      half_n  = ({1'b0, act_n} + CW'(1)) >> 1;
      phase_n = run_n && ({1'b0, cnt_n} < half_n);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         act_q   <= DIV_W'(RST_DIV);
         run_q   <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         act_q   <= act_n;
         run_q   <= run_n;
         phase_q <= phase_n;
      end
   end

   assign phase_o = phase_q;
   assign run_o   = run_q;
   assign act_o   = act_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/pbdiv_gate.sv
module pbdiv_gate #(
   parameter bit ALLOW_BYPASS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic unity_i,
   input  logic phase_i,
   output logic clk_o
);

   generate
      if (ALLOW_BYPASS) begin : g_bypass
         logic pass_q;
         // Updated on the falling edge, while the parent clock is low.
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pass_q <= 1'b0;
            else         pass_q <= run_i && unity_i;
         end
         assign clk_o = phase_i | (clk_i & pass_q);
      end else begin : g_plain
         assign clk_o = phase_i;
      end
   endgenerate

endmodule

// File: rtl/pbclk_div.sv
module pbclk_div #(
   parameter int unsigned DIV_W        = 7,
   parameter int unsigned REG_W        = 16,
   parameter int unsigned RDY_BIT      = 11,
   parameter int unsigned EN_BIT       = 15,
   parameter int unsigned RST_DIV      = 0,
   parameter bit          ALLOW_BYPASS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             pb_clk_o
);

   localparam int unsigned MAX_CODE = (1 << DIV_W) - 1;

   generate
      if (DIV_W < 1 || DIV_W > 12) begin : g_bad_width
         $error("divisor width out of range");
      end
      if (RDY_BIT >= REG_W || EN_BIT >= REG_W || RDY_BIT < DIV_W || EN_BIT < DIV_W
          || RDY_BIT == EN_BIT) begin : g_bad_bits
         $error("flag positions overlap or fall outside the word");
      end
      if (RST_DIV > MAX_CODE) begin : g_bad_reset
         $error("reset divisor does not fit the field");
      end
   endgenerate

   logic [DIV_W-1:0] div_w, act_w, cnt_w;
   logic             en_w, pend_w, load_w, phase_w, run_w;

   pbdiv_regs #(
      .DIV_W(DIV_W), .REG_W(REG_W), .RDY_BIT(RDY_BIT),
      .EN_BIT(EN_BIT), .RST_DIV(RST_DIV)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .load_i(load_w),
      .div_o(div_w), .en_o(en_w), .pend_o(pend_w), .rd_data_o(rd_data_o)
   );

   pbdiv_core #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .div_i(div_w), .en_i(en_w), .pend_i(pend_w),
      .load_o(load_w), .phase_o(phase_w), .run_o(run_w),
      .act_o(act_w), .cnt_o(cnt_w)
   );

   pbdiv_gate #(.ALLOW_BYPASS(ALLOW_BYPASS)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .run_i(run_w), .unity_i(act_w == '0), .phase_i(phase_w),
      .clk_o(pb_clk_o)
   );

endmodule

// File: rtl/pbclk_div_chk.sv
module pbclk_div_chk #(
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned REG_W   = 16,
   parameter int unsigned RDY_BIT = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic [REG_W-1:0] rd_data_i,
   input logic [DIV_W-1:0] act_i,
   input logic [DIV_W-1:0] cnt_i,
   input logic             phase_i,
   input logic             run_i
);

   // R3
   ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !rd_data_i[RDY_BIT]);

   // R1
   code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(rd_data_i[DIV_W-1:0]));

   // R5
   boundary_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_i) |-> (cnt_i == '0));

   // R6
   gated_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phase_i) |-> run_i);

   // R2
   unity_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i == '0) |-> !phase_i);

endmodule

bind pbclk_div pbclk_div_chk #(.DIV_W(DIV_W), .REG_W(REG_W), .RDY_BIT(RDY_BIT)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_data_i(rd_data_o),
   .act_i(act_w), .cnt_i(cnt_w), .phase_i(phase_w), .run_i(run_w)
);

// File: tb/pbclk_div_test.sv
module pbclk_div_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        pb_clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pbclk_div uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .pb_clk_o(pb_clk)
   );

   // code, expected high cycles, expected low cycles
   localparam int VEC [6][3] = '{
      '{1, 1, 1}, '{2, 1, 2}, '{3, 2, 2}, '{4, 2, 3}, '{6, 3, 4}, '{127, 64, 64}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] word(input bit en, input int code);
      return {en, 8'h00, 7'(code)};
   endfunction

   // Write at a falling edge; taken at the next rising edge.
   task automatic write_word(input logic [15:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ready(output bit got);
      got = 1'b0;
      for (int i = 0; i < 400 && !got; i++) begin
         @(negedge clk);
         got = rd_data[11];
      end
   endtask

   task automatic measure(output int hi, output int lo);
      int n;
      hi = 0; lo = 0; n = 0;
      @(negedge clk);
      while (pb_clk && n < 600) begin @(negedge clk); n++; end
      while (!pb_clk && n < 600) begin @(negedge clk); n++; end
      while (pb_clk && n < 600) begin hi++; @(negedge clk); n++; end
      while (!pb_clk && n < 600) begin lo++; @(negedge clk); n++; end
   endtask

   initial begin
      wait (cyc >= 100000 || done);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      bit got;
      int hi, lo;
      logic samp [80];
      int bad, runlen, nruns;

      repeat (3) @(negedge clk);
      // R8 reset values
      check(rd_data == 16'h0800, "R8 reset word", rd_data, 16'h0800);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(pb_clk == 1'b0, "R8 output low after reset", pb_clk, 0);

      // Table of ratios
      for (int v = 0; v < 6; v++) begin
         write_word(word(1'b1, VEC[v][0]));
         // R3 ready low the cycle after the write
         check(rd_data[11] == 1'b0, "R3 ready drop", rd_data[11], 0);
         wait_ready(got);
         // R4 ready returns
         check(got, "R4 ready return", got, 1);
         // R1 R4 readback of new code
         check(rd_data[6:0] == 7'(VEC[v][0]), "R1 R4 code readback", rd_data[6:0], VEC[v][0]);
         measure(hi, lo);
         // R2 phase lengths
         check(hi == VEC[v][1], "R2 high length", hi, VEC[v][1]);
         check(lo == VEC[v][2], "R2 low length", lo, VEC[v][2]);
      end

      // R3 the ready bit itself is not writable
      write_word(16'h0800 | word(1'b1, 3));
      check(rd_data[11] == 1'b0, "R3 ready bit not writable", rd_data[11], 0);
      wait_ready(got);

      // R2 ratio of one follows the parent clock
      write_word(word(1'b1, 0));
      wait_ready(got);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         check(pb_clk == 1'b1, "R2 unity high with parent", pb_clk, 1);
         @(negedge clk); #1;
         check(pb_clk == 1'b0, "R2 unity low with parent", pb_clk, 0);
      end

      // R5 change mid-period from ratio 8 to ratio 3
      write_word(word(1'b1, 7));
      wait_ready(got);
      repeat (3) @(negedge clk);
      write_word(word(1'b1, 2));
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         samp[i] = pb_clk;
      end
      bad = 0; runlen = 0; nruns = 0;
      for (int i = 1; i < 80; i++) begin
         if (samp[i] != samp[i-1]) begin
            if (nruns > 0) begin
               if (samp[i-1] && !(runlen == 4 || runlen == 1)) bad++;
               if (!samp[i-1] && !(runlen == 4 || runlen == 2)) bad++;
            end
            nruns++;
            runlen = 1;
         end else begin
            runlen++;
         end
      end
      check(bad == 0, "R5 no cut-short phase", bad, 0);
      check(nruns > 10, "R5 output toggles through change", nruns, 11);

      // R6 disable keeps the code and holds output low
      write_word(word(1'b1, 3));
      wait_ready(got);
      write_word(word(1'b0, 3));
      wait_ready(got);
      repeat (8) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1;
         if (pb_clk) bad++;
         @(negedge clk);
         if (pb_clk) bad++;
      end
      check(bad == 0, "R6 output held low", bad, 0);
      check(rd_data[6:0] == 7'd3, "R6 code kept", rd_data[6:0], 3);
      check(rd_data[15] == 1'b0, "R6 enable reads clear", rd_data[15], 0);

      // R7 re-enable restarts with full phases
      write_word(word(1'b1, 3));
      wait_ready(got);
      measure(hi, lo);
      check(hi == 2, "R7 restart high length", hi, 2);
      check(lo == 2, "R7 restart low length", lo, 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule